// File: doc/BRIEF.md
# Column Voltage-Island Mask Controller

This block sets the supply state of every column of a SIMD processing array, where each column forms one voltage island. All processors in a column share one state: shut off, powered but idle, running on the low rail, or running on the high rail. The state is chosen from the class of the instruction sent to each column. Slow instructions need the high rail: the multiply/accumulate family and the absolute-sum-plus-add operation. Every other arithmetic, logic or bitwise operation is fast and runs on the low rail.

The block has two policies. In the per-cycle policy (`policy_i` = 0), each column's state follows that cycle's activity and class bits with no delay. Which columns are shut off is fixed when a task starts and is held until the next start. In the per-task policy (`policy_i` = 1), a full mask is loaded ahead of the task and held. Each load is followed by a fixed settle period. During that period the block refuses new loads and keeps the task from starting. While the task runs, the block blocks, and flags, any slow instruction aimed at a column that is not on the high rail.

Top module: `colisland_ctrl`

## Requirements
- R1: After reset, every column reports Sleep, and `busy_o`, `col_issue_o` and `col_viol_o` are all zero.
- R2: The state of column c is the 2-bit field `col_state_o[2c+1:2c]`, with 00 = Sleep, 01 = Idle, 10 = Run on the low rail, 11 = Run on the high rail. `mask_data_i` uses the same layout.
- R3: In the per-cycle policy, a column that is not shut off reports 11 when it is active with its slow bit set, 10 when it is active with its slow bit clear, and 01 when it is inactive. The change shows in the same cycle as the inputs.
- R4: In the per-cycle policy, an accepted task start shuts off exactly the columns that were inactive in that cycle. Those columns report 00 whatever their inputs, and the other columns never report 00, until the next accepted start. Before the first start, all columns report 00.
- R5: In the per-task policy, `col_state_o` equals the last accepted mask. A mask load is accepted only in the per-task policy and only when `busy_o` is low.
- R6: `busy_o` is high for exactly SETTLE_CYC (default 4) cycles after the edge that accepts a mask load.
- R7: A mask load presented while `busy_o` is high leaves the mask unchanged.
- R8: A task start that arrives while `busy_o` is high is held, and is accepted in the first cycle with `busy_o` low. The task then runs from the following cycle. No column issues while `busy_o` is high.
- R9: In the per-task policy, while a task runs, a column issues when it is active, its mask code is 10 or 11, and it has no violation.
- R10: In the per-task policy, while a task runs, an active slow instruction on a column whose code is 00 or 10 raises that column's `col_viol_o` bit and does not issue. The per-cycle policy never raises violations.
- R11: In the per-cycle policy, once a task has started, a column issues when it is active and not shut off.
- R12: A column issues a slow instruction only while it reports 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy_i | input | 1 | 0 = per-cycle policy, 1 = per-task policy |
| task_start_i | input | 1 | Task start request |
| col_active_i | input | 16 | Per-column instruction-valid flags |
| col_slow_i | input | 16 | Per-column instruction class, 1 = needs high rail |
| mask_load_i | input | 1 | Mask load request (per-task policy) |
| mask_data_i | input | 32 | Mask to load, 2 bits per column |
| col_state_o | output | 32 | Per-column state codes |
| col_issue_o | output | 16 | Per-column instruction issued this cycle |
| col_viol_o | output | 16 | Per-column class violation this cycle |
| busy_o | output | 1 | Settle period in progress |

## Verification
The per-cycle policy is swept with 32 scrambled activity and class patterns across all 16 columns. This runs after two different task starts with different shut-off sets, so a column that wrongly wakes, or a class-to-rail swap, shows up column by column. The per-task policy loads a mask that holds every code in turn. The same kind of sweep then separates the four code-dependent results: violation on Sleep and low rail, issue on high rail, and blocking on Idle. The settle window is checked cycle by cycle, with a load and a start sent in during it. This shows whether a late load leaks into the mask, whether the busy period is one cycle too long or too short, and whether a held start is lost or taken too early.

// File: rtl/cvi_pkg.sv
package cvi_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'b00,
    ST_IDLE  = 2'b01,
    ST_RUNLO = 2'b10,
    ST_RUNHI = 2'b11
  } col_st_e;

  // State derived in the per-cycle policy from one column's inputs.
  function automatic logic [1:0] pc_code(input logic off, input logic act, input logic slow);
    if (off)       return ST_SLEEP;
    else if (!act) return ST_IDLE;
    else if (slow) return ST_RUNHI;
    else           return ST_RUNLO;
  endfunction

  // True for the codes that cannot carry a slow instruction (Sleep, Run low).
  function automatic logic lacks_high(input logic [1:0] code);
    return ~code[0];
  endfunction

  // True for either Run code.
  function automatic logic is_run(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/cvi_settle.sv
module cvi_settle #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_req,
  input  logic start_req,
  output logic busy,
  output logic load_acc,
  output logic start_acc
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          idle;

  assign idle      = (cnt_q == '0);
  assign busy      = ~idle;
  assign load_acc  = load_req & idle;
  assign start_acc = (start_req | pend_q) & idle & ~load_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (load_acc)   cnt_q <= CW'(SETTLE_CYC);
      else if (!idle) cnt_q <= cnt_q - 1'b1;
      if (start_req && (busy || load_acc)) pend_q <= 1'b1;
      else if (start_acc)                  pend_q <= 1'b0;
    end
  end

  // R6: an accepted load opens the settle window
  p_load_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> busy);
  // R8: no start is taken during the settle window
  p_start_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_acc);
  // R7: no load is taken during the settle window
  p_load_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_acc);

endmodule

// File: rtl/cvi_column.sv
module cvi_column
  import cvi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       policy,
  input  logic       run,
  input  logic       off,
  input  logic       act,
  input  logic       slow,
  input  logic [1:0] mask_code,
  output logic [1:0] code,
  output logic       viol,
  output logic       issue
);
  logic [1:0] pc;

  assign pc = pc_code(off, act, slow);

  always_comb begin
    if (policy) begin
      code  = mask_code;
      viol  = run & act & slow & lacks_high(mask_code);
      issue = run & act & is_run(mask_code) & ~viol;
    end else begin
      code  = pc;
      viol  = 1'b0;
      issue = run & act & ~off;
    end
  end

  // R12: slow work reaches only high-rail columns
  p_slow_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && slow) |-> (code == 2'b11));
  // R10: a flagged instruction is never issued
  p_viol_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> !issue);
  // R4: a shut-off column never issues in the per-cycle policy
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!policy && off) |-> (!issue && code == 2'b00));

endmodule

// File: rtl/colisland_ctrl.sv
module colisland_ctrl
  import cvi_pkg::*;
#(
  parameter int NCOLS      = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 policy_i,
  input  logic                 task_start_i,
  input  logic [NCOLS-1:0]     col_active_i,
  input  logic [NCOLS-1:0]     col_slow_i,
  input  logic                 mask_load_i,
  input  logic [2*NCOLS-1:0]   mask_data_i,
  output logic [2*NCOLS-1:0]   col_state_o,
  output logic [NCOLS-1:0]     col_issue_o,
  output logic [NCOLS-1:0]     col_viol_o,
  output logic                 busy_o
);
  localparam int MW = 2 * NCOLS;

  logic             load_acc, start_acc, busy;
  logic [MW-1:0]    mask_q;
  logic [NCOLS-1:0] off_q;
  logic             run_q;

  cvi_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (mask_load_i & policy_i),
    .start_req (task_start_i),
    .busy      (busy),
    .load_acc  (load_acc),
    .start_acc (start_acc)
  );

  assign busy_o = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      off_q  <= '1;
      run_q  <= 1'b0;
    end else begin
      if (load_acc) mask_q <= mask_data_i;
      if (start_acc && !policy_i) off_q <= ~col_active_i;
      if (load_acc)       run_q <= 1'b0;
      else if (start_acc) run_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    cvi_column u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .policy    (policy_i),
      .run       (run_q),
      .off       (off_q[c]),
      .act       (col_active_i[c]),
      .slow      (col_slow_i[c]),
      .mask_code (mask_q[2*c +: 2]),
      .code      (col_state_o[2*c +: 2]),
      .viol      (col_viol_o[c]),
      .issue     (col_issue_o[c])
    );
  end

  // R4: the shut-off set moves only on an accepted per-cycle start
  p_off_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_acc && !policy_i) |=> $stable(off_q));
  // R7: the mask is frozen through the settle window
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mask_q));
  // R8: nothing issues while settling
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (col_issue_o == '0));
  // R10: per-cycle policy raises no violation
  p_pc_noviol_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !policy_i |-> (col_viol_o == '0));

endmodule

// File: tb/colisland_ctrl_tb.sv
module colisland_ctrl_tb;
  localparam int N = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            policy_i = 1'b0;
  logic            task_start_i = 1'b0;
  logic [N-1:0]    col_active_i = '0;
  logic [N-1:0]    col_slow_i = '0;
  logic            mask_load_i = 1'b0;
  logic [2*N-1:0]  mask_data_i = '0;
  logic [2*N-1:0]  col_state_o;
  logic [N-1:0]    col_issue_o;
  logic [N-1:0]    col_viol_o;
  logic            busy_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  colisland_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .task_start_i(task_start_i),
    .col_active_i(col_active_i), .col_slow_i(col_slow_i),
    .mask_load_i(mask_load_i), .mask_data_i(mask_data_i),
    .col_state_o(col_state_o), .col_issue_o(col_issue_o),
    .col_viol_o(col_viol_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at falling edge, settle, then look
  task automatic at_neg();
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] pat_a(input int k);
    return 16'hA5C3 ^ 16'((k * 16'h1357) ^ (k << 5));
  endfunction
  function automatic logic [N-1:0] pat_s(input int k);
    return 16'h3C69 ^ 16'((k * 16'h0F1D) + k);
  endfunction

  // per-cycle expectation built from R2/R3/R4/R11
  task automatic check_pc(input logic [N-1:0] offs, input logic started);
    logic [2*N-1:0] es;
    logic [N-1:0]   ei;
    for (int c = 0; c < N; c++) begin
      if (offs[c])              es[2*c +: 2] = 2'd0;
      else if (!col_active_i[c]) es[2*c +: 2] = 2'd1;
      else                      es[2*c +: 2] = col_slow_i[c] ? 2'd3 : 2'd2;
      ei[c] = started & col_active_i[c] & ~offs[c];
    end
    chk("R3/R4 per-cycle state", col_state_o, es);
    chk("R11 per-cycle issue", 32'(col_issue_o), 32'(ei));
    chk("R10 per-cycle no violation", 32'(col_viol_o), 32'd0);
  endtask

  // per-task expectation built from R5/R9/R10/R12
  task automatic check_pt(input logic [2*N-1:0] m, input logic running);
    logic [N-1:0] ev, ei;
    for (int c = 0; c < N; c++) begin
      logic [1:0] cd;
      cd = m[2*c +: 2];
      ev[c] = running & col_active_i[c] & col_slow_i[c] & (cd == 2'd0 || cd == 2'd2);
      ei[c] = running & col_active_i[c] & (cd == 2'd2 || cd == 2'd3) & ~ev[c];
      if (ei[c] && col_slow_i[c] && cd != 2'd3) ei[c] = 1'b1; // kept for R12 check below
    end
    chk("R5 per-task state", col_state_o, m);
    chk("R10 violation", 32'(col_viol_o), 32'(ev));
    chk("R9 per-task issue", 32'(col_issue_o), 32'(ei));
    for (int c = 0; c < N; c++)
      if (col_issue_o[c] && col_slow_i[c])
        chk("R12 slow only on high", 32'(col_state_o[2*c +: 2]), 32'd3);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0]   offs;
    logic [2*N-1:0] m;
    repeat (3) @(posedge clk);
    at_neg(); rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 state", col_state_o, 32'd0);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 issue", 32'(col_issue_o), 32'd0);
    chk("R1 viol", 32'(col_viol_o), 32'd0);

    // R4 before any start: all shut off
    at_neg(); col_active_i = 16'hFFFF; col_slow_i = 16'h00FF; #2;
    check_pc(16'hFFFF, 1'b0);

    // per-cycle task 1
    at_neg(); col_active_i = 16'h0FF0; task_start_i = 1'b1;
    at_neg(); task_start_i = 1'b0;
    offs = ~16'h0FF0;
    for (int k = 0; k < 32; k++) begin
      col_active_i = pat_a(k); col_slow_i = pat_s(k); #2;
      check_pc(offs, 1'b1);
      at_neg();
    end
    // per-cycle task 2: new shut-off set (R4)
    col_active_i = 16'hF00F; task_start_i = 1'b1;
    at_neg(); task_start_i = 1'b0;
    offs = ~16'hF00F;
    for (int k = 0; k < 32; k++) begin
      col_active_i = pat_a(k + 40); col_slow_i = pat_s(k + 7); #2;
      check_pc(offs, 1'b1);
      at_neg();
    end

    // R5: load ignored in per-cycle policy
    mask_load_i = 1'b1; mask_data_i = 32'hFFFF_FFFF;
    at_neg(); mask_load_i = 1'b0; #2;
    chk("R5 no busy in per-cycle", 32'(busy_o), 32'd0);
    at_neg(); policy_i = 1'b1; #2;
    chk("R5 per-cycle load ignored", col_state_o, 32'd0);

    // per-task: mask holds code c%4 in column c (R2)
    for (int c = 0; c < N; c++) m[2*c +: 2] = 2'(c % 4);
    at_neg(); mask_load_i = 1'b1; mask_data_i = m;
    at_neg(); #2;
    chk("R6 busy cycle 1", 32'(busy_o), 32'd1);
    chk("R5 mask applied", col_state_o, m);
    mask_data_i = 32'h5555_AAAA; task_start_i = 1'b1;   // R7 load and R8 start while busy
    col_active_i = 16'hFFFF; col_slow_i = 16'hFFFF;
    at_neg(); mask_load_i = 1'b0; task_start_i = 1'b0; #2;
    chk("R7 late load ignored", col_state_o, m);
    chk("R8 no issue while busy", 32'(col_issue_o), 32'd0);
    for (int i = 2; i <= 4; i++) begin
      chk("R6 busy window", 32'(busy_o), 32'd1);
      at_neg(); #2;
    end
    chk("R6 busy ends after 4", 32'(busy_o), 32'd0);
    chk("R8 start not yet running", 32'(col_issue_o), 32'd0);
    at_neg(); #2;
    check_pt(m, 1'b1);  // R8 held start now running
    for (int k = 0; k < 32; k++) begin
      at_neg(); col_active_i = pat_a(k + 3); col_slow_i = pat_s(k + 11); #2;
      check_pt(m, 1'b1);
    end
    chk("R7 mask kept", col_state_o, m);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule